// File: doc/BRIEF.md
# Sticky Overflow Status Register

This block keeps the integer status word that arithmetic operations report into. Three flags sit at the top of a 32-bit word, numbered from the most significant end: a sticky summary flag, a per-operation overflow flag and a carry flag. The datapath computes overflow and carry elsewhere and presents each one with its own valid strobe. The overflow flag follows the latest reporting operation. The summary flag collects every overflow since software last cleared it, so a long run of arithmetic can be checked with one test at the end.

Software can replace the whole word or read it back. An extract operation hands the three flags, plus a zero pad bit, to a 4-bit condition field and clears the flags in the same step. When one operation also writes a condition field, that writer needs the summary value as it stands after this cycle's update. The block therefore presents the next-state summary bit combinationally, so the condition field sees the current overflow without waiting a cycle.

Top module: `ovf_status_reg`

## Requirements
- R1: A synchronous active-high reset clears the whole word to zero.
- R2: When `ovf_vld` is high, the overflow flag (word bit 30) takes the value of `ovf_in` on the next edge and drops its previous value.
- R3: When `ovf_vld` is high, the summary flag (word bit 31) becomes its old value OR `ovf_in`. It keeps a 1 until an extract, a write or a reset clears it.
- R4: The carry flag (word bit 29) loads `ca_in` only when `ca_vld` is high. `ovf_vld` has no effect on it.
- R5: `xtr_field` always shows {bit 31, bit 30, bit 29, 0} of the current word, with the summary flag in field bit 3. When `xtr_en` is high, bits 31..29 read zero after the edge.
- R6: When `wr_en` is high, the word takes `wr_data` on the next edge. This takes priority over extract and over both arithmetic updates in the same cycle.
- R7: `rd_data` always shows the current word.
- R8: `so_fwd` equals the value bit 31 will hold after the coming edge, so it includes this cycle's overflow.
- R9: Bits 28..0 change only on a write. Arithmetic updates and extracts leave them as they were.
- R10: When an extract and an arithmetic update arrive in the same cycle without a write, the extract wins and all three flags are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ovf_vld | input | 1 | Overflow result valid |
| ovf_in | input | 1 | Signed overflow of the current operation |
| ca_vld | input | 1 | Carry result valid |
| ca_in | input | 1 | Carry of the current operation |
| wr_en | input | 1 | Whole-word write strobe |
| wr_data | input | 32 | Word to write |
| xtr_en | input | 1 | Extract-and-clear strobe |
| rd_data | output | 32 | Current word |
| xtr_field | output | 4 | Flags packed for a condition field, pad bit zero |
| so_fwd | output | 1 | Post-update summary flag |

## Verification
The bench builds the block with its default parameters: a 32-bit word and a 4-bit condition field. With these values the zero pad bit in the field is visible, and so are the 29 passive low bits. That means a stray arithmetic or extract update to the low bits, or a nonzero pad, shows up at the ports. A random phase exercises the three priority levels (write, extract, arithmetic) in every combination, and includes cycles where the summary flag is already set when overflow arrives.

// File: rtl/ovf_pkg.sv
package ovf_pkg;

    localparam int FLAG_N = 3;

    // Field order matches word bits MSB-first: summary, overflow, carry.
    typedef struct packed {
        logic so;
        logic ov;
        logic ca;
    } ovf_flags_t;

    typedef struct packed {
        logic vld;
        logic val;
    } upd_t;

    function automatic ovf_flags_t arith_step(input ovf_flags_t cur,
                                              input upd_t ov_u,
                                              input upd_t ca_u);
        ovf_flags_t r;
        r = cur;
        if (ov_u.vld) begin
            r.ov = ov_u.val;
            r.so = cur.so | ov_u.val;
        end
        if (ca_u.vld) begin
            r.ca = ca_u.val;
        end
        return r;
    endfunction

endpackage

// File: rtl/ovf_update.sv
module ovf_update
    import ovf_pkg::*;
(
    input  ovf_flags_t cur,
    input  upd_t       ov_u,
    input  upd_t       ca_u,
    input  logic       xtr_en,
    input  logic       wr_en,
    input  ovf_flags_t wr_flags,
    output ovf_flags_t nxt
);

    always_comb begin
        if (wr_en) begin
            nxt = wr_flags;
        end else if (xtr_en) begin
            nxt = '0;
        end else begin
            nxt = arith_step(cur, ov_u, ca_u);
        end
    end

endmodule

// File: rtl/ovf_field_pack.sv
module ovf_field_pack
    import ovf_pkg::*;
#(
    parameter int FIELD_W = 4
) (
    input  ovf_flags_t         flags,
    output logic [FIELD_W-1:0] field
);

    logic [FLAG_N-1:0] fv;
    assign fv = flags;

    for (genvar i = 0; i < FIELD_W; i++) begin : g_slot
        if (i < FLAG_N) begin : g_flag
            assign field[FIELD_W-1-i] = fv[FLAG_N-1-i];
        end else begin : g_pad
            assign field[FIELD_W-1-i] = 1'b0;
        end
    end

endmodule

// File: rtl/ovf_store.sv
module ovf_store
    import ovf_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LOW_W = DATA_W - FLAG_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LOW_W-1:0]  wr_low,
    input  ovf_flags_t        nxt,
    output logic [DATA_W-1:0] word
);

    ovf_flags_t       flags_q;
    logic [LOW_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            low_q   <= '0;
        end else begin
            flags_q <= nxt;
            if (wr_en) begin
                low_q <= wr_low;
            end
        end
    end

    assign word = {flags_q, low_q};

endmodule

// File: rtl/ovf_status_reg.sv
module ovf_status_reg
    import ovf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 4,
    localparam int LOW_W  = DATA_W - FLAG_N
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ovf_vld,
    input  logic               ovf_in,
    input  logic               ca_vld,
    input  logic               ca_in,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               xtr_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic [FIELD_W-1:0] xtr_field,
    output logic               so_fwd
);

    ovf_flags_t cur_flags;
    ovf_flags_t nxt_flags;
    ovf_flags_t wr_flags;
    upd_t       ov_u;
    upd_t       ca_u;
    logic [DATA_W-1:0] word;

    assign cur_flags = ovf_flags_t'(word[DATA_W-1 -: FLAG_N]);
    assign wr_flags  = ovf_flags_t'(wr_data[DATA_W-1 -: FLAG_N]);
    assign ov_u      = '{vld: ovf_vld, val: ovf_in};
    assign ca_u      = '{vld: ca_vld,  val: ca_in};

    ovf_update u_update (
        .cur      (cur_flags),
        .ov_u     (ov_u),
        .ca_u     (ca_u),
        .xtr_en   (xtr_en),
        .wr_en    (wr_en),
        .wr_flags (wr_flags),
        .nxt      (nxt_flags)
    );

    ovf_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_low (wr_data[LOW_W-1:0]),
        .nxt    (nxt_flags),
        .word   (word)
    );

    ovf_field_pack #(.FIELD_W(FIELD_W)) u_pack (
        .flags (cur_flags),
        .field (xtr_field)
    );

    assign rd_data = word;
    assign so_fwd  = nxt_flags.so;

    AST_OV_TRACK: assert property (@(posedge clk) disable iff (rst)
        (ovf_vld && !wr_en && !xtr_en) |=> rd_data[DATA_W-2] == $past(ovf_in)); // R2
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rd_data[DATA_W-1] && !wr_en && !xtr_en) |=> rd_data[DATA_W-1]); // R3
    AST_CA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ca_vld && !wr_en && !xtr_en) |=> $stable(rd_data[DATA_W-3])); // R4
    AST_XTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (xtr_en && !wr_en) |=> rd_data[DATA_W-1 -: FLAG_N] == '0); // R10
    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_data == $past(wr_data)); // R6
    AST_FWD_MATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rd_data[DATA_W-1] == $past(so_fwd)); // R8
    AST_LOW_KEEP: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_data[LOW_W-1:0])); // R9
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
        xtr_field[0] == 1'b0); // R5

endmodule

// File: tb/sim_ovf_status_reg.sv
module sim_ovf_status_reg;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ovf_vld = 0, ovf_in = 0, ca_vld = 0, ca_in = 0;
    logic        wr_en = 0, xtr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  xtr_field;
    logic        so_fwd;

    int checks = 0;
    int fails  = 0;
    bit [31:0] model = '0;
    bit done = 0;

    always #2 clk = ~clk;

    ovf_status_reg u0 (
        .clk(clk), .rst(rst), .ovf_vld(ovf_vld), .ovf_in(ovf_in),
        .ca_vld(ca_vld), .ca_in(ca_in), .wr_en(wr_en), .wr_data(wr_data),
        .xtr_en(xtr_en), .rd_data(rd_data), .xtr_field(xtr_field), .so_fwd(so_fwd)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] model_next(input bit [31:0] m);
        bit [31:0] n = m;
        if (wr_en) n = wr_data;
        else if (xtr_en) n[31:29] = 3'b000;
        else begin
            if (ovf_vld) begin n[30] = ovf_in; n[31] = m[31] | ovf_in; end
            if (ca_vld) n[29] = ca_in;
        end
        return n;
    endfunction

    // Inputs already driven after a falling edge; compare, then advance one clock.
    task automatic tick();
        bit [31:0] n;
        #1;
        n = model_next(model);
        chk("R7 rd_data", rd_data, model);
        chk("R5 xtr_field", {28'd0, xtr_field}, {28'd0, model[31:29], 1'b0});
        chk("R8 so_fwd", {31'd0, so_fwd}, {31'd0, n[31]});
        @(posedge clk);
        model = n;
        @(negedge clk);
    endtask

    task automatic idle();
        ovf_vld = 0; ovf_in = 0; ca_vld = 0; ca_in = 0;
        wr_en = 0; xtr_en = 0; wr_data = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        wr_en = 1; wr_data = 32'hDEAD_BEEF;
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle();
        rst = 0;
        #1 chk("R1 reset clears", rd_data, 32'h0);
        model = '0;

        // R6 / R9 write all ones, then extract
        wr_en = 1; wr_data = 32'hFFFF_FFFF; tick(); idle();
        chk("R6 write", rd_data, 32'hFFFF_FFFF);
        #1 chk("R5 field 1110", {28'd0, xtr_field}, 32'hE);
        xtr_en = 1; tick(); idle();
        chk("R5 R9 extract clears flags only", rd_data, 32'h1FFF_FFFF);

        // R2 R3 overflow then no overflow
        ovf_vld = 1; ovf_in = 1;
        #1 chk("R8 forward includes current overflow", {31'd0, so_fwd}, 32'h1);
        tick(); idle();
        chk("R2 R3 overflow set", rd_data, 32'hDFFF_FFFF);
        ovf_vld = 1; ovf_in = 0; tick(); idle();
        chk("R2 replace R3 sticky", rd_data, 32'h9FFF_FFFF);

        // R4 carry gated by its strobe
        ca_in = 1; ovf_vld = 1; ovf_in = 0; tick(); idle();
        chk("R4 carry ignored without strobe", rd_data, 32'h9FFF_FFFF);
        ca_vld = 1; ca_in = 1; tick(); idle();
        chk("R4 carry loaded", rd_data, 32'hBFFF_FFFF);

        // R10 extract beats arithmetic
        xtr_en = 1; ovf_vld = 1; ovf_in = 1; ca_vld = 1; ca_in = 1;
        #1 chk("R8 forward zero on extract", {31'd0, so_fwd}, 32'h0);
        tick(); idle();
        chk("R10 extract wins", rd_data, 32'h1FFF_FFFF);

        // R6 write beats arithmetic and extract
        wr_en = 1; wr_data = 32'h1234_5678; xtr_en = 1; ovf_vld = 1; ovf_in = 1;
        ca_vld = 1; ca_in = 1; tick(); idle();
        chk("R6 write wins", rd_data, 32'h1234_5678);

        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 99);
            ovf_vld = $urandom_range(0, 1) == 1;
            ovf_in  = $urandom_range(0, 3) == 0;
            ca_vld  = $urandom_range(0, 1) == 1;
            ca_in   = $urandom_range(0, 1) == 1;
            wr_en   = r < 8;
            xtr_en  = r >= 8 && r < 20 || r == 3;
            wr_data = $urandom();
            tick();
        end
        idle();
        tick();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule